// File: doc/BRIEF.md
# Dual-Port Configuration Register File

This block holds a small bank of 64-bit configuration registers that two requesters can reach. One is a configuration-bus port and the other is a memory-mapped port. Each port sends a request: a write flag, a byte address and write data. The block turns the address into a register index. On the configuration port the index is the byte address shifted right by three. On the memory-mapped port a fixed skew of 0x0A is added after the shift, so memory offset 0 lands on the base-address register. Every access is a full 64-bit word.

The bank includes a fault register with AND and OR write aliases, and a control register with set and clear write aliases. It also has a masked base-address register that only the configuration port may change, a second address register that keeps only a window of its bits, a read-only interrupt-status view, and four plain registers. The stored base address, its enable bit and the control word are driven out as plain pins. A one-cycle pulse marks every change of control bit 62, the memory-mapped enable.

Requests use valid/ready. The configuration port is never stalled. When both ports request in the same cycle the configuration port wins, and the memory-mapped port sees ready low and must hold its request until it is accepted. Every accepted access gets a response one cycle later on the port that issued it. The response carries the read data and an error flag, and it has no ready: the requester must take it.

Top module: `cfgrf_top`

## Requirements
- R1: On the configuration port the register index is byte address >> 3; the three low address bits have no effect on which register is reached.
- R2: On the memory-mapped port the index is (byte address >> 3) + 0x0A, so memory offset 0x00 reaches the base-address register and offset 0x50 reaches index 0x14.
- R3: Index 0x00 is the fault register (read-write). A write to index 0x01 stores fault AND data, and a write to index 0x02 stores fault OR data.
- R4: Index 0x0E is the control register (read-write). A write to index 0x12 stores control OR data, and a write to index 0x13 stores control AND NOT data. The control word drives `ctrl_bits`.
- R5: Index 0x0A, the base-address register, keeps only bits 51:20 and enable bit 0 of a write; `base_addr` shows bits 51:20 and `base_en` shows bit 0. A write from the memory-mapped port leaves it unchanged and returns error = 1.
- R6: Index 0x0B keeps only bits 49:32 of a written value; all its other bits read as 0.
- R7: Index 0x15 reads the current `irq_status` input. A write to it changes nothing and returns error = 1.
- R8: A read of an index that is not readable (including the alias indices 0x01, 0x02, 0x12 and 0x13) returns all ones with error = 0. A write to an index with no write meaning returns error = 1 and changes nothing.
- R9: Indices 0x06, 0x07, 0x0F and 0x14 are plain registers that store and return the full 64 bits.
- R10: After reset every register is zero, except the base-address register, which holds the masked `BASE_DEFAULT` with enable bit 0 set.
- R11: `mmio_en_toggle` is high for exactly the one cycle after an accepted write that changed control bit 62, and is low otherwise.
- R12: `cfg_ready` is always 1 and `mmio_ready` equals NOT `cfg_valid`. An accepted access raises the issuing port's response valid for one cycle on the next cycle. The response carries the read value from before that edge (0 for writes) and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration-port request valid |
| cfg_ready | output | 1 | Configuration-port request accepted |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Configuration-port byte address |
| cfg_wdata | input | 64 | Configuration-port write data |
| cfg_rsp_valid | output | 1 | Configuration-port response valid |
| cfg_rsp_data | output | 64 | Configuration-port read data |
| cfg_rsp_err | output | 1 | Configuration-port access error |
| mmio_valid | input | 1 | Memory-mapped request valid |
| mmio_ready | output | 1 | Memory-mapped request accepted |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | ADDR_W | Memory-mapped byte offset |
| mmio_wdata | input | 64 | Memory-mapped write data |
| mmio_rsp_valid | output | 1 | Memory-mapped response valid |
| mmio_rsp_data | output | 64 | Memory-mapped read data |
| mmio_rsp_err | output | 1 | Memory-mapped access error |
| irq_status | input | 64 | Live interrupt status shown at index 0x15 |
| base_addr | output | 64 | Masked base address (bits 51:20) |
| base_en | output | 1 | Base-address enable |
| ctrl_bits | output | 64 | Control register contents |
| mmio_en_toggle | output | 1 | One-cycle pulse on a change of control bit 62 |

## Verification
The assertions assume that each requester holds its request stable while ready is low. They also assume that `irq_status` is a clean level sampled only on reads, and that reset is applied before any request. The stimulus drives every input on the falling edge and lowers valid once a request has been accepted. Each collision it builds has the memory-mapped request already present when the configuration request arrives, so the blocked request is simply retried in the next step. The byte addresses stay within range, so the memory-mapped skew never wraps the index.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
  localparam int IDX_W = 6;
  localparam int DW    = 64;

  localparam logic [IDX_W-1:0] IX_FAULT     = 6'h00;
  localparam logic [IDX_W-1:0] IX_FAULT_AND = 6'h01;
  localparam logic [IDX_W-1:0] IX_FAULT_OR  = 6'h02;
  localparam logic [IDX_W-1:0] IX_ACT0      = 6'h06;
  localparam logic [IDX_W-1:0] IX_ACT1      = 6'h07;
  localparam logic [IDX_W-1:0] IX_BASE      = 6'h0A;
  localparam logic [IDX_W-1:0] IX_AUXBASE   = 6'h0B;
  localparam logic [IDX_W-1:0] IX_CTRL      = 6'h0E;
  localparam logic [IDX_W-1:0] IX_ERRMASK   = 6'h0F;
  localparam logic [IDX_W-1:0] IX_CTRL_SET  = 6'h12;
  localparam logic [IDX_W-1:0] IX_CTRL_CLR  = 6'h13;
  localparam logic [IDX_W-1:0] IX_DMAHI     = 6'h14;
  localparam logic [IDX_W-1:0] IX_ISTAT     = 6'h15;

  localparam logic [IDX_W-1:0] MMIO_SKEW = 6'h0A;
  localparam int MMIO_EN_BIT = 62;

  typedef struct packed {
    logic             wr;
    logic             from_mmio;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    data;
  } acc_t;
endpackage

// File: rtl/cfgrf_arb.sv
module cfgrf_arb
  import cfgrf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              mmio_valid,
  input  logic              mmio_write,
  input  logic [ADDR_W-1:0] mmio_addr,
  input  logic [DW-1:0]     mmio_wdata,
  output logic              cfg_ready,
  output logic              mmio_ready,
  output logic              acc_valid,
  output acc_t              acc
);
  localparam int NPORT = 2;

  logic [NPORT-1:0][ADDR_W-1:0] addr_a;
  logic [NPORT-1:0]             wr_a;
  logic [NPORT-1:0][DW-1:0]     data_a;
  acc_t [NPORT-1:0]             pkt;

  assign addr_a = {mmio_addr, cfg_addr};
  assign wr_a   = {mmio_write, cfg_write};
  assign data_a = {mmio_wdata, cfg_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [IDX_W-1:0] SKEW = (p == 1) ? MMIO_SKEW : '0;
    assign pkt[p].wr        = wr_a[p];
    assign pkt[p].from_mmio = (p == 1);
    assign pkt[p].idx       = IDX_W'(addr_a[p] >> 3) + SKEW;
    assign pkt[p].data      = data_a[p];
  end

  assign cfg_ready  = 1'b1;
  assign mmio_ready = !cfg_valid;
  assign acc_valid  = cfg_valid || mmio_valid;
  assign acc        = cfg_valid ? pkt[0] : pkt[1];
endmodule

// File: rtl/cfgrf_regs.sv
module cfgrf_regs
  import cfgrf_pkg::*;
#(
  parameter logic [DW-1:0] BASE_DEFAULT = 64'h0000_0123_4567_89AB,
  parameter int BASE_LO = 20,
  parameter int BASE_HI = 51,
  parameter int AUX_LO  = 32,
  parameter int AUX_HI  = 49
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  acc_t          acc,
  input  logic [DW-1:0] irq_status,
  output logic [DW-1:0] rd_data,
  output logic          wr_err,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] ctrl_q,
  output logic          toggle_q
);
  localparam logic [DW-1:0] BASE_FIELD = ((DW'(1) << (BASE_HI - BASE_LO + 1)) - 1) << BASE_LO;
  localparam logic [DW-1:0] BASE_KEEP  = BASE_FIELD | DW'(1);
  localparam logic [DW-1:0] AUX_KEEP   = ((DW'(1) << (AUX_HI - AUX_LO + 1)) - 1) << AUX_LO;

  logic [DW-1:0] fault_q, act0_q, act1_q, aux_q, emask_q, dmahi_q;
  logic [DW-1:0] ctrl_nx;
  logic          do_wr, writable;

  assign do_wr = acc_valid && acc.wr;

  always_comb begin
    unique case (acc.idx)
      IX_FAULT:   rd_data = fault_q;
      IX_ACT0:    rd_data = act0_q;
      IX_ACT1:    rd_data = act1_q;
      IX_BASE:    rd_data = base_q;
      IX_AUXBASE: rd_data = aux_q;
      IX_CTRL:    rd_data = ctrl_q;
      IX_ERRMASK: rd_data = emask_q;
      IX_DMAHI:   rd_data = dmahi_q;
      IX_ISTAT:   rd_data = irq_status;
      default:    rd_data = '1;
    endcase
  end

  always_comb begin
    case (acc.idx)
      IX_FAULT, IX_FAULT_AND, IX_FAULT_OR, IX_ACT0, IX_ACT1, IX_AUXBASE,
      IX_CTRL, IX_ERRMASK, IX_CTRL_SET, IX_CTRL_CLR, IX_DMAHI: writable = 1'b1;
      IX_BASE:  writable = !acc.from_mmio;
      default:  writable = 1'b0;
    endcase
    wr_err = acc.wr && !writable;
  end

  always_comb begin
    ctrl_nx = ctrl_q;
    if (do_wr) begin
      case (acc.idx)
        IX_CTRL:     ctrl_nx = acc.data;
        IX_CTRL_SET: ctrl_nx = ctrl_q | acc.data;
        IX_CTRL_CLR: ctrl_nx = ctrl_q & ~acc.data;
        default:     ctrl_nx = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= '0;
      act0_q   <= '0;
      act1_q   <= '0;
      base_q   <= (BASE_DEFAULT & BASE_FIELD) | DW'(1);
      aux_q    <= '0;
      ctrl_q   <= '0;
      emask_q  <= '0;
      dmahi_q  <= '0;
      toggle_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_nx;
      toggle_q <= ctrl_nx[MMIO_EN_BIT] ^ ctrl_q[MMIO_EN_BIT];
      if (do_wr) begin
        case (acc.idx)
          IX_FAULT:     fault_q <= acc.data;
          IX_FAULT_AND: fault_q <= fault_q & acc.data;
          IX_FAULT_OR:  fault_q <= fault_q | acc.data;
          IX_ACT0:      act0_q  <= acc.data;
          IX_ACT1:      act1_q  <= acc.data;
          IX_BASE:      if (!acc.from_mmio) base_q <= acc.data & BASE_KEEP;
          IX_AUXBASE:   aux_q   <= acc.data & AUX_KEEP;
          IX_ERRMASK:   emask_q <= acc.data;
          IX_DMAHI:     dmahi_q <= acc.data;
          default: ;
        endcase
      end
    end
  end

  a_r5_mmio_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && acc.from_mmio && acc.idx == IX_BASE) |=> $stable(base_q));

  a_r3_or_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && acc.idx == IX_FAULT_OR) |=> ((fault_q & $past(acc.data)) == $past(acc.data)));

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && acc.idx == IX_CTRL_SET) |=> ((ctrl_q & $past(acc.data)) == $past(acc.data)));

  a_r11_toggle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_q |-> (ctrl_q[MMIO_EN_BIT] != $past(ctrl_q[MMIO_EN_BIT])));
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
  import cfgrf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0123_4567_89AB,
  parameter int BASE_LO = 20,
  parameter int BASE_HI = 51,
  parameter int AUX_LO  = 32,
  parameter int AUX_HI  = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_write,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic              cfg_rsp_valid,
  output logic [63:0]       cfg_rsp_data,
  output logic              cfg_rsp_err,
  input  logic              mmio_valid,
  output logic              mmio_ready,
  input  logic              mmio_write,
  input  logic [ADDR_W-1:0] mmio_addr,
  input  logic [63:0]       mmio_wdata,
  output logic              mmio_rsp_valid,
  output logic [63:0]       mmio_rsp_data,
  output logic              mmio_rsp_err,
  input  logic [63:0]       irq_status,
  output logic [63:0]       base_addr,
  output logic              base_en,
  output logic [63:0]       ctrl_bits,
  output logic              mmio_en_toggle
);
  localparam logic [63:0] BASE_FIELD = ((64'(1) << (BASE_HI - BASE_LO + 1)) - 1) << BASE_LO;

  logic          acc_valid;
  acc_t          acc;
  logic [DW-1:0] rd_data, base_q;
  logic          wr_err;
  logic          cfg_rv_q, mmio_rv_q, err_q;
  logic [DW-1:0] data_q;

  cfgrf_arb #(.ADDR_W(ADDR_W)) u_arb (
    .cfg_valid (cfg_valid),  .cfg_write (cfg_write),  .cfg_addr (cfg_addr),  .cfg_wdata (cfg_wdata),
    .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata),
    .cfg_ready (cfg_ready),  .mmio_ready(mmio_ready), .acc_valid(acc_valid), .acc(acc)
  );

  cfgrf_regs #(
    .BASE_DEFAULT(BASE_DEFAULT), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
    .AUX_LO(AUX_LO), .AUX_HI(AUX_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc(acc),
    .irq_status(irq_status), .rd_data(rd_data), .wr_err(wr_err),
    .base_q(base_q), .ctrl_q(ctrl_bits), .toggle_q(mmio_en_toggle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rv_q  <= 1'b0;
      mmio_rv_q <= 1'b0;
      err_q     <= 1'b0;
      data_q    <= '0;
    end else begin
      cfg_rv_q  <= acc_valid && !acc.from_mmio;
      mmio_rv_q <= acc_valid && acc.from_mmio;
      err_q     <= acc_valid && wr_err;
      data_q    <= (acc_valid && !acc.wr) ? rd_data : '0;
    end
  end

  assign cfg_rsp_valid  = cfg_rv_q;
  assign mmio_rsp_valid = mmio_rv_q;
  assign cfg_rsp_data   = data_q;
  assign mmio_rsp_data  = data_q;
  assign cfg_rsp_err    = err_q;
  assign mmio_rsp_err   = err_q;
  assign base_addr      = base_q & BASE_FIELD;
  assign base_en        = base_q[0];

  a_r12_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_rsp_valid, mmio_rsp_valid}));

  a_r7_status_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc.wr && acc.idx == IX_ISTAT) |=> (cfg_rsp_err || mmio_rsp_err));

  a_r12_collision_to_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && mmio_valid) |=> (cfg_rsp_valid && !mmio_rsp_valid));
endmodule

// File: tb/test_cfgrf_top.sv
module test_cfgrf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_valid = 0, cfg_write = 0, mmio_valid = 0, mmio_write = 0;
  logic [7:0] cfg_addr = 0, mmio_addr = 0;
  logic [63:0] cfg_wdata = 0, mmio_wdata = 0, irq_status = 64'h0000_0010_0000_0000;
  logic cfg_ready, mmio_ready, cfg_rsp_valid, mmio_rsp_valid, cfg_rsp_err, mmio_rsp_err;
  logic [63:0] cfg_rsp_data, mmio_rsp_data, base_addr, ctrl_bits;
  logic base_en, mmio_en_toggle;

  cfgrf_top i_cfgrf_top (.*);

  localparam logic [63:0] DEF    = 64'h0000_0123_4567_89AB;
  localparam logic [63:0] M_BASE = 64'h000F_FFFF_FFF0_0000;
  localparam logic [63:0] M_AUX  = 64'h0003_FFFF_0000_0000;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, keyed by register index
  logic [63:0] mreg [int];
  logic        e_cv, e_mv, e_err, e_tog;
  logic [63:0] e_data;

  function automatic logic [63:0] rd(int i);
    case (i)
      0, 6, 7, 'h0A, 'h0B, 'h0E, 'h0F, 'h14: return mreg[i];
      'h15: return irq_status;
      default: return '1;
    endcase
  endfunction

  task automatic model(bit w, int i, logic [63:0] d, bit from_m);
    logic [63:0] old_c = mreg['h0E];
    e_err = 0; e_data = w ? 64'h0 : rd(i);
    if (w) case (i)
      0, 6, 7, 'h0F, 'h14: mreg[i] = d;
      1: mreg[0] = mreg[0] & d;
      2: mreg[0] = mreg[0] | d;
      'h0A: if (from_m) e_err = 1; else mreg['h0A] = d & (M_BASE | 64'h1);
      'h0B: mreg['h0B] = d & M_AUX;
      'h0E: mreg['h0E] = d;
      'h12: mreg['h0E] = old_c | d;
      'h13: mreg['h0E] = old_c & ~d;
      default: e_err = 1;
    endcase
    e_tog = (mreg['h0E][62] != old_c[62]);
  endtask

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compare(string tag);
    checks++;
    if (cfg_rsp_valid !== e_cv) fail(tag, "cfg_rsp_valid", 64'(cfg_rsp_valid), 64'(e_cv));
    if (mmio_rsp_valid !== e_mv) fail(tag, "mmio_rsp_valid", 64'(mmio_rsp_valid), 64'(e_mv));
    if (e_cv && (cfg_rsp_data !== e_data || cfg_rsp_err !== e_err))
      fail(tag, "cfg rsp data/err", cfg_rsp_data ^ 64'(cfg_rsp_err), e_data ^ 64'(e_err));
    if (e_mv && (mmio_rsp_data !== e_data || mmio_rsp_err !== e_err))
      fail(tag, "mmio rsp data/err", mmio_rsp_data ^ 64'(mmio_rsp_err), e_data ^ 64'(e_err));
    if (base_addr !== (mreg['h0A] & M_BASE)) fail(tag, "base_addr", base_addr, mreg['h0A] & M_BASE);
    if (base_en !== mreg['h0A][0]) fail(tag, "base_en", 64'(base_en), 64'(mreg['h0A][0]));
    if (ctrl_bits !== mreg['h0E]) fail(tag, "ctrl_bits", ctrl_bits, mreg['h0E]);
    if (mmio_en_toggle !== e_tog) fail(tag, "mmio_en_toggle", 64'(mmio_en_toggle), 64'(e_tog));
  endtask

  // one clock: drive at falling edge, predict, compare at next falling edge
  task automatic step(string tag, bit cv, bit cw, logic [7:0] ca, logic [63:0] cd,
                      bit mv, bit mw, logic [7:0] ma, logic [63:0] md);
    cfg_valid = cv; cfg_write = cw; cfg_addr = ca; cfg_wdata = cd;
    mmio_valid = mv; mmio_write = mw; mmio_addr = ma; mmio_wdata = md;
    #1;
    checks++;
    if (cfg_ready !== 1'b1 || mmio_ready !== !cv)
      fail(tag, "ready (R12)", {62'h0, cfg_ready, mmio_ready}, {62'h0, 1'b1, !cv});
    e_cv = cv; e_mv = mv && !cv; e_tog = 0; e_err = 0; e_data = 0;
    if (cv) model(cw, int'(ca >> 3), cd, 0);
    else if (mv) model(mw, int'(ma >> 3) + 'h0A, md, 1);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cw_(string t, logic [7:0] a, logic [63:0] d); step(t, 1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic cr_(string t, logic [7:0] a); step(t, 1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic mw_(string t, logic [7:0] a, logic [63:0] d); step(t, 0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic mr_(string t, logic [7:0] a); step(t, 0, 0, 0, 0, 1, 0, a, 0); endtask
  task automatic idle(string t); step(t, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mreg[k]) mreg.delete(k);
    for (int i = 0; i < 64; i++) mreg[i] = 64'h0;
    mreg['h0A] = (DEF & M_BASE) | 64'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    idle("R10");
    cr_("R10", 8'h00); cr_("R10", 8'h50); cr_("R10", 8'h70); cr_("R10", 8'h58);
    // R7: status view follows input
    cr_("R7", 8'hA8);
    irq_status = 64'h0000_0003_0000_0000;
    cr_("R7", 8'hA8);
    cw_("R7", 8'hA8, 64'hFFFF);
    cr_("R7", 8'hA8);
    // R3: fault aliases
    cw_("R3", 8'h00, 64'hF0F0_0000_0000_00FF);
    cw_("R3", 8'h08, 64'hFF00_0000_0000_000F);
    cr_("R3", 8'h00);
    cw_("R3", 8'h10, 64'h0000_0001_0000_0100);
    cr_("R3", 8'h00);
    // R4 and R11: control aliases and enable-change pulse
    cw_("R4", 8'h70, 64'h8000_0000_0000_0001);
    cw_("R11", 8'h90, 64'h4000_0000_0000_0002);
    idle("R11");
    cw_("R11", 8'h90, 64'h4000_0000_0000_0000);
    cw_("R11", 8'h98, 64'h4000_0000_0000_0001);
    cr_("R4", 8'h70);
    mw_("R11", 8'h20, 64'h4000_0000_0000_0000);
    // R5: base register masking and port permission
    cw_("R5", 8'h50, 64'hFFFF_FFFF_FFFF_FFFE);
    cr_("R5", 8'h50);
    cw_("R5", 8'h50, 64'h0001_2345_6789_0001);
    mw_("R5", 8'h00, 64'h0);
    mr_("R2", 8'h00);
    // R6: auxiliary base window
    cw_("R6", 8'h58, 64'hFFFF_FFFF_FFFF_FFFF);
    cr_("R6", 8'h58);
    // R8: unreadable / unwritable indices
    cr_("R8", 8'h18); cr_("R8", 8'h08); cr_("R8", 8'h90); cr_("R8", 8'hF8);
    cw_("R8", 8'hF8, 64'h1234);
    cw_("R8", 8'h18, 64'h1234);
    // R9 and R2: plain registers through both ports
    cw_("R9", 8'h30, 64'h0123_4567_89AB_CDEF);
    cw_("R9", 8'h38, 64'hFEDC_BA98_7654_3210);
    cw_("R9", 8'h78, 64'hAAAA_5555_AAAA_5555);
    mw_("R2", 8'h50, 64'h5A5A_0000_FFFF_1111);
    cr_("R9", 8'hA0); cr_("R9", 8'h30); cr_("R9", 8'h38); mr_("R2", 8'h28);
    // R1: low address bits ignored
    cw_("R1", 8'h77, 64'h0000_0000_0000_00C3);
    cr_("R1", 8'h72);
    // R12: collision, configuration port wins, memory-mapped retried
    step("R12", 1, 0, 8'h30, 0, 1, 1, 8'h50, 64'h77);
    step("R12", 1, 1, 8'h38, 64'h99, 1, 1, 8'h50, 64'h77);
    mw_("R12", 8'h50, 64'h77);
    cr_("R12", 8'hA0);
    idle("R12");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule